// File: doc/BRIEF.md
# Masked Interrupt Collector

This block gathers interrupt events from five sources into one level interrupt line for a processor. The sources are timer A, timer B, the time-of-day alarm, the serial shifter and an external flag pin. Each source delivers a one-cycle pulse. A pulse sets a sticky pending flag. A separate enable mask decides which pending flags may raise the interrupt line.

Software changes the mask with one write. The top data bit of that write selects the operation: when it is 1, the ones in the lower bits are added to the mask; when it is 0, they are removed from the mask. Software services the interrupt by reading the flag byte. The byte holds the pending flags plus a summary bit that mirrors the interrupt line. The read clears the flags and drops the line. If a mask write enables a source whose flag is already pending, the line rises at once, with no new pulse needed.

The summary bit and the output are sticky. Once raised, they stay up until a read, even if the mask is later cleared. A pulse that arrives in the same cycle as the read is kept as a new flag and is not lost.

Top module: `irq_collector`

## Requirements
- R1: The read byte `rd_data_o` is laid out as follows:
  - bit 0 is timer A, bit 1 is timer B, bit 2 is the alarm, bit 3 is the serial port and bit 4 is the flag pin;
  - bits 6:5 always read 0;
  - bit 7 is the summary bit and always equals `irq_o`.
- R2: A mask write with `wr_data_i[7]=1` adds to the mask every source whose bit in `wr_data_i[4:0]` is 1. Sources whose bit is 0 are left unchanged.
- R3: A mask write with `wr_data_i[7]=0` removes from the mask every source whose bit in `wr_data_i[4:0]` is 1. Sources whose bit is 0 are left unchanged.
- R4: A pulse on `src_i[k]` sets flag k at the next clock edge, whatever the mask holds. If source k is enabled (using the mask as updated by a write in the same cycle), the summary bit and `irq_o` rise at that same edge.
- R5: After a mask write, if any flag is both pending and enabled, the summary bit and `irq_o` rise at the next edge, even if no pulse arrives.
- R6: `rd_data_o` gives the current byte during a cycle with `rd_i` high. At the following edge all flags, the summary bit and `irq_o` clear, unless R7 applies.
- R7: A pulse that arrives in the same cycle as a read sets its flag after the clear. If its source is enabled, `irq_o` is high after the edge.
- R8: `irq_o` stays high until a read, even when the mask is cleared. It never rises unless some flag is both pending and enabled.
- R9: While `rst_ni` is low, the mask, the flags and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 5 | One-cycle event pulses, one bit per source |
| mask_wr_i | input | 1 | Mask write strobe |
| wr_data_i | input | 8 | Mask write data; bit 7 selects set or clear |
| rd_i | input | 1 | Read strobe; clears the flags at the edge |
| rd_data_o | output | 8 | Flag byte: summary in bit 7, flags in bits 4:0 |
| irq_o | output | 1 | Registered active-high interrupt level |

## Verification
The following are checked on every cycle:
- a pulse always leaves its flag set;
- a set or clear write moves exactly the addressed mask bits;
- a read with no coincident pulse empties the byte;
- the line never drops without a read;
- the line never rises without an enabled pending flag.

Other behaviour needs orderings that only the bench's scenarios create:
- an early pulse followed by a late enable;
- a pulse that lands on the read cycle;
- a mask clear while the line is high.

The random stream mixes these orderings, and a reference model predicts the full byte after each cycle.

// File: rtl/irq_collector_pkg.sv
package irq_collector_pkg;
  localparam int unsigned SRC_TMR_A = 0;
  localparam int unsigned SRC_TMR_B = 1;
  localparam int unsigned SRC_ALARM = 2;
  localparam int unsigned SRC_SER   = 3;
  localparam int unsigned SRC_PIN   = 4;
  localparam int unsigned NUM_SRC_DEF = 5;
  localparam int unsigned DATA_W_DEF  = 8;

  typedef enum logic {
    MASK_CLR = 1'b0,
    MASK_SET = 1'b1
  } mask_op_e;
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned NUM_SRC = 5,
  parameter int unsigned DATA_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] mask_nxt_o
);
  import irq_collector_pkg::*;

  localparam int unsigned OP_BIT = DATA_W - 1;

  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] sel;
  mask_op_e           op;

  assign sel = wr_data_i[NUM_SRC-1:0];
  assign op  = mask_op_e'(wr_data_i[OP_BIT]);

  always_comb begin
    mask_nxt_o = mask_q;
    if (wr_i) begin
      if (op == MASK_SET) mask_nxt_o = mask_q | sel;
      else                mask_nxt_o = mask_q & ~sel;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= mask_nxt_o;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
  parameter int unsigned NUM_SRC = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               rd_i,
  input  logic               mask_wr_i,
  input  logic [NUM_SRC-1:0] mask_nxt_i,
  output logic [NUM_SRC-1:0] flags_o,
  output logic               sum_o
);
  logic [NUM_SRC-1:0] flags_q, flags_nxt;
  logic               sum_q, sum_nxt;
  logic               hit_src, hit_wr;

  // Clear on read first, then merge new pulses so none is lost.
  assign flags_nxt = (rd_i ? '0 : flags_q) | src_i;
  assign hit_src   = |(src_i & mask_nxt_i);
  assign hit_wr    = mask_wr_i & |(flags_nxt & mask_nxt_i);
  assign sum_nxt   = (rd_i ? 1'b0 : sum_q) | hit_src | hit_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      sum_q   <= 1'b0;
    end else begin
      flags_q <= flags_nxt;
      sum_q   <= sum_nxt;
    end
  end

  assign flags_o = flags_q;
  assign sum_o   = sum_q;
endmodule

// File: rtl/irq_collector.sv
module irq_collector #(
  parameter int unsigned NUM_SRC = irq_collector_pkg::NUM_SRC_DEF,
  parameter int unsigned DATA_W  = irq_collector_pkg::DATA_W_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               mask_wr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               rd_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               irq_o
);
  localparam int unsigned SUM_BIT = DATA_W - 1;

  logic [NUM_SRC-1:0] mask_q, mask_nxt, flags_q;
  logic               sum_q;

  irq_mask_reg #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_mask (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (mask_wr_i),
    .wr_data_i  (wr_data_i),
    .mask_o     (mask_q),
    .mask_nxt_o (mask_nxt)
  );

  irq_flag_reg #(.NUM_SRC(NUM_SRC)) u_flag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (src_i),
    .rd_i       (rd_i),
    .mask_wr_i  (mask_wr_i),
    .mask_nxt_i (mask_nxt),
    .flags_o    (flags_q),
    .sum_o      (sum_q)
  );

  always_comb begin
    rd_data_o                = '0;
    rd_data_o[NUM_SRC-1:0]   = flags_q;
    rd_data_o[SUM_BIT]       = sum_q;
  end

  assign irq_o = sum_q;
endmodule

// File: rtl/irq_collector_chk.sv
module irq_collector_chk #(
  parameter int unsigned NUM_SRC = 5,
  parameter int unsigned DATA_W  = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] src_i,
  input logic               mask_wr_i,
  input logic [DATA_W-1:0]  wr_data_i,
  input logic               rd_i,
  input logic [DATA_W-1:0]  rd_data_o,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] mask_q
);
  localparam int unsigned SUM_BIT = DATA_W - 1;

  p_pulse_sets_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_i) |=> ((rd_data_o[NUM_SRC-1:0] & $past(src_i)) == $past(src_i)));

  p_mask_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_wr_i && wr_data_i[SUM_BIT]) |=>
      (mask_q == ($past(mask_q) | $past(wr_data_i[NUM_SRC-1:0]))));

  p_mask_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_wr_i && !wr_data_i[SUM_BIT]) |=>
      (mask_q == ($past(mask_q) & ~$past(wr_data_i[NUM_SRC-1:0]))));

  p_read_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && src_i == '0) |=> (rd_data_o == '0 && !irq_o));

  p_irq_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !rd_i) |=> irq_o);

  p_irq_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (|(rd_data_o[NUM_SRC-1:0] & mask_q)));

  always_comb begin
    if (rst_ni) begin
      p_layout_r1: assert (rd_data_o[SUM_BIT] == irq_o &&
                           rd_data_o[SUM_BIT-1:NUM_SRC] == '0);
    end
  end
endmodule

bind irq_collector irq_collector_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .src_i     (src_i),
  .mask_wr_i (mask_wr_i),
  .wr_data_i (wr_data_i),
  .rd_i      (rd_i),
  .rd_data_o (rd_data_o),
  .irq_o     (irq_o),
  .mask_q    (mask_q)
);

// File: tb/tb_irq_collector.sv
`timescale 1ns/1ps
module tb_irq_collector;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] src_i = '0;
  logic       mask_wr_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       rd_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  logic [4:0] m_mask = '0, m_flags = '0;
  logic       m_sum = 1'b0;

  always #2.5 clk_i = ~clk_i;

  irq_collector dut (.*);

  function automatic logic [4:0] nxt_mask(logic [4:0] m, logic wr, logic [7:0] d);
    if (!wr) return m;
    return d[7] ? (m | d[4:0]) : (m & ~d[4:0]);
  endfunction

  function automatic logic [7:0] exp_byte(logic s, logic [4:0] f);
    return {s, 2'b00, f};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one cycle at negedge, check byte during cycle, update model at edge.
  task automatic step(string req, logic [4:0] s, logic wr, logic [7:0] d, logic rd);
    logic [4:0] mn, fn;
    @(negedge clk_i);
    src_i = s; mask_wr_i = wr; wr_data_i = d; rd_i = rd;
    #1;
    chk({req, " byte"}, rd_data_o, exp_byte(m_sum, m_flags));
    chk({req, " irq"}, {7'd0, irq_o}, {7'd0, m_sum});
    @(posedge clk_i);
    mn = nxt_mask(m_mask, wr, d);
    fn = (rd ? 5'd0 : m_flags) | s;
    m_sum = (rd ? 1'b0 : m_sum) | (|(s & mn)) | (wr & |(fn & mn));
    m_flags = fn;
    m_mask = mn;
  endtask

  task automatic idle_chk(string req);
    step(req, 5'd0, 1'b0, 8'd0, 1'b0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    #1;
    chk("R9 reset byte", rd_data_o, 8'h00);
    chk("R9 reset irq", {7'd0, irq_o}, 8'h00);
    repeat (2) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R4: pulse with mask empty sets flag only
    step("R4", 5'b00100, 1'b0, 8'h00, 1'b0);
    idle_chk("R4 flag no irq");
    // R5: enabling pending alarm raises irq
    step("R5 R2", 5'd0, 1'b1, 8'h84, 1'b0);
    idle_chk("R5 irq up");
    // R3 + R8: clearing mask keeps irq
    step("R3 R8", 5'd0, 1'b1, 8'h04, 1'b0);
    idle_chk("R8 sticky");
    // R6: read clears
    step("R6 read", 5'd0, 1'b0, 8'h00, 1'b1);
    idle_chk("R6 cleared");
    // R3: masked source no irq
    step("R3 masked pulse", 5'b00100, 1'b0, 8'h00, 1'b0);
    idle_chk("R3 no irq");
    step("R6 read2", 5'd0, 1'b0, 8'h00, 1'b1);
    // R7: pulse on read cycle kept, enabled
    step("R2 set ta", 5'd0, 1'b1, 8'h81, 1'b0);
    step("R4 ta", 5'b00001, 1'b0, 8'h00, 1'b0);
    step("R7 read+pulse", 5'b00001, 1'b0, 8'h00, 1'b1);
    idle_chk("R7 kept");
    step("R7 read", 5'd0, 1'b0, 8'h00, 1'b1);
    // R1: all sources, bits 6:5 stay zero even with wide mask data
    step("R1 mask all", 5'd0, 1'b1, 8'hFF, 1'b0);
    step("R1 all src", 5'b11111, 1'b0, 8'h00, 1'b0);
    idle_chk("R1 layout");
    step("R1 read", 5'd0, 1'b0, 8'h00, 1'b1);
    step("R3 clr all", 5'd0, 1'b1, 8'h7F, 1'b0);

    for (int i = 0; i < 3000; i++) begin
      logic [4:0] s;
      logic wr, rd;
      logic [7:0] d;
      s  = (($urandom % 4) == 0) ? 5'(1 << ($urandom % 5)) : 5'd0;
      if (($urandom % 16) == 0) s = 5'($urandom);
      wr = (($urandom % 6) == 0);
      d  = 8'($urandom);
      rd = (($urandom % 7) == 0);
      step("R4 R5 R6 R7 random", s, wr, d, rd);
    end
    idle_chk("R8 final");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule